// File: doc/BRIEF.md
# Single-Bit Manipulation Execute Unit

This unit carries out the four immediate single-bit operations of the bit-manipulation extension: clear, extract, invert and set. It takes a 32-bit instruction word, a 2-bit operation select, the value of the first source register and the extension-enable bit. From these it forms a one-hot mask at the bit position named by the instruction's shift-amount field and applies the selected operation. The result, the destination register number, a write-enable and an illegal-instruction flag come out one cycle later, behind a valid strobe.

The `XLEN` parameter selects a 32-bit or a 64-bit datapath. On the 32-bit build, shift amounts of 32 and above are reserved encodings and are flagged as illegal. When the extension is present but disabled by its enable bit, every operation is flagged as illegal. The source register number is decoded without a register stage, so that a register file can be read in the same cycle.

Top module: `bitop_exec`

## Requirements
- R1: After a synchronous active-high reset, `out_valid`, `rd_we` and `illegal` are 0.
- R2: `out_valid` is 1 in the cycle after a cycle with `in_valid` high, and 0 in the cycle after a cycle with `in_valid` low.
- R3: The bit index is the low log2(XLEN) bits of the shift amount. The shift amount is taken from instruction bits 25:20 when XLEN is 64 and from bits 24:20 when XLEN is 32.
- R4: With `op` = 00 (clear), the result is rs1 AND NOT mask, where mask is a 1 shifted left by the index within XLEN bits.
- R5: With `op` = 01 (extract), the result is 1 when rs1 AND mask is nonzero and 0 otherwise, zero-extended to XLEN bits.
- R6: With `op` = 10 (invert), the result is rs1 XOR mask.
- R7: With `op` = 11 (set), the result is rs1 OR mask.
- R8: `rd_idx` is instruction bits 11:7, registered along with the result. `src_idx` is instruction bits 19:15 and follows `insn` in the same cycle.
- R9: An operation whose destination field is 0 gives `rd_we` = 0, but the result is still computed.
- R10: When `ext_en` is 0 (and `EXT_GATED` is 1), the operation gives `illegal` = 1, `rd_we` = 0 and a result of 0.
- R11: When XLEN is 32, an instruction with bit 25 set gives `illegal` = 1, `rd_we` = 0 and a result of 0.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous reset, active high |
| in_valid | input | 1 | Operation present this cycle |
| insn | input | 32 | Instruction word |
| op | input | 2 | 00 clear, 01 extract, 10 invert, 11 set |
| rs1_val | input | XLEN | Value of the first source register |
| ext_en | input | 1 | Extension enable bit |
| src_idx | output | 5 | Source register number, combinational |
| out_valid | output | 1 | Result valid |
| result | output | XLEN | Operation result |
| rd_idx | output | 5 | Destination register number |
| rd_we | output | 1 | Destination write enable |
| illegal | output | 1 | Illegal-instruction flag |

## Verification
The same stimulus drives a 64-bit and a 32-bit build side by side. A single shift-amount value with bit 5 set therefore selects an upper bit on one build and a reserved encoding on the other. Directed vectors cover index 0, 31 and 63, extract on a set bit and on a clear bit, a destination of 0, and a disabled extension. Each of these separates the four operations and shows whether the index is masked correctly. Random instructions and operand values are then mixed with occasional gaps in the valid strobe and occasional disables. This checks that flags and results depend only on the operation in the previous cycle.

// File: rtl/bitop_exec.sv
module bitop_exec #(
  parameter int XLEN = 64,
  parameter bit EXT_GATED = 1'b1
) (
  input  logic            clk,
  input  logic            rst,
  input  logic            in_valid,
  input  logic [31:0]     insn,
  input  logic [1:0]      op,
  input  logic [XLEN-1:0] rs1_val,
  input  logic            ext_en,
  output logic [4:0]      src_idx,
  output logic            out_valid,
  output logic [XLEN-1:0] result,
  output logic [4:0]      rd_idx,
  output logic            rd_we,
  output logic            illegal
);
  localparam int IW = $clog2(XLEN);

  logic [5:0]      shamt;
  logic [IW-1:0]   bit_idx;
  logic [XLEN-1:0] mask;
  logic [XLEN-1:0] op_res;
  logic [4:0]      dst;
  logic            reserved, disabled, bad;

  assign shamt    = insn[25:20];
  assign bit_idx  = shamt[IW-1:0];
  assign mask     = {{(XLEN-1){1'b0}}, 1'b1} << bit_idx;
  assign dst      = insn[11:7];
  assign src_idx  = insn[19:15];
  assign reserved = (XLEN == 32) && insn[25];
  assign disabled = EXT_GATED && !ext_en;
  assign bad      = reserved || disabled;

  always_comb begin
    case (op)
      2'b00:   op_res = rs1_val & ~mask;
      2'b01:   op_res = {{(XLEN-1){1'b0}}, |(rs1_val & mask)};
      2'b10:   op_res = rs1_val ^ mask;
      default: op_res = rs1_val | mask;
    endcase
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      out_valid <= 1'b0;
      rd_we     <= 1'b0;
      illegal   <= 1'b0;
      result    <= '0;
      rd_idx    <= '0;
    end else begin
      out_valid <= in_valid;
      illegal   <= in_valid && bad;
      rd_we     <= in_valid && !bad && (dst != 5'd0);
      result    <= (in_valid && !bad) ? op_res : '0;
      rd_idx    <= dst;
    end
  end

  p_valid_lat_r2: assert property (@(posedge clk) disable iff (rst)
    in_valid |=> out_valid);
  p_idle_r2: assert property (@(posedge clk) disable iff (rst)
    !in_valid |=> !out_valid);
  p_zero_dst_r9: assert property (@(posedge clk) disable iff (rst)
    (out_valid && rd_idx == 5'd0) |-> !rd_we);
  p_ill_quiet_r10: assert property (@(posedge clk) disable iff (rst)
    illegal |-> (!rd_we && result == '0));
  p_disabled_r10: assert property (@(posedge clk) disable iff (rst)
    (in_valid && EXT_GATED && !ext_en) |=> illegal);
  p_extract_r5: assert property (@(posedge clk) disable iff (rst)
    (in_valid && op == 2'b01) |=> (result[XLEN-1:1] == '0));
  p_flags_r1: assert property (@(posedge clk) disable iff (rst)
    !out_valid |-> (!rd_we && !illegal));

  if (XLEN == 32) begin : g_rv32_chk
    p_reserved_r11: assert property (@(posedge clk) disable iff (rst)
      (in_valid && insn[25]) |=> (illegal && !rd_we));
  end
endmodule

// File: tb/sim_bitop_exec.sv
module sim_bitop_exec;
  logic        clk = 1'b0;
  logic        rst = 1'b1;
  logic        in_valid = 1'b0;
  logic [31:0] insn = '0;
  logic [1:0]  op = '0;
  logic [63:0] rs1 = '0;
  logic        ext_en = 1'b1;

  logic [4:0]  src64, src32, rd64, rd32;
  logic        v64, v32, we64, we32, ill64, ill32;
  logic [63:0] res64;
  logic [31:0] res32;

  int vectors = 0;
  int fails = 0;
  bit done = 1'b0;

  always #5 clk = ~clk;

  bitop_exec #(.XLEN(64)) u0 (
    .clk(clk), .rst(rst), .in_valid(in_valid), .insn(insn), .op(op),
    .rs1_val(rs1), .ext_en(ext_en), .src_idx(src64), .out_valid(v64),
    .result(res64), .rd_idx(rd64), .rd_we(we64), .illegal(ill64));

  bitop_exec #(.XLEN(32)) u1 (
    .clk(clk), .rst(rst), .in_valid(in_valid), .insn(insn), .op(op),
    .rs1_val(rs1[31:0]), .ext_en(ext_en), .src_idx(src32), .out_valid(v32),
    .result(res32), .rd_idx(rd32), .rd_we(we32), .illegal(ill32));

  function automatic logic [63:0] model(input int xlen, input logic [31:0] w,
      input logic [1:0] o, input logic [63:0] a, input logic en,
      output logic ill, output logic we);
    logic [5:0]  ix;
    logic [63:0] m, r, av;
    ix  = (xlen == 64) ? w[25:20] : {1'b0, w[24:20]};
    ill = !en || (xlen == 32 && w[25]);
    av  = (xlen == 64) ? a : {32'd0, a[31:0]};
    m   = 64'd1 << ix;
    case (o)
      2'b00: r = av & ~m;
      2'b01: r = {63'd0, |(av & m)};
      2'b10: r = av ^ m;
      default: r = av | m;
    endcase
    if (xlen == 32) r[63:32] = '0;
    if (ill) r = '0;
    we = !ill && (w[11:7] != 5'd0);
    return r;
  endfunction

  task automatic chk(input string req, input string what, input logic [63:0] act, input logic [63:0] exp);
    vectors++;
    if (act !== exp) begin
      fails++;
      $display("FAIL %s %s: got %h expected %h", req, what, act, exp);
    end
  endtask

  task automatic apply(input logic [31:0] w, input logic [1:0] o,
      input logic [63:0] a, input logic en, input logic vld, input string req);
    logic [63:0] e64, e32;
    logic i64, i32, w64, w32;
    @(negedge clk);
    insn = w; op = o; rs1 = a; ext_en = en; in_valid = vld;
    #1;
    chk("R8", "src_idx", {59'd0, src64}, {59'd0, w[19:15]});
    chk("R8", "src_idx32", {59'd0, src32}, {59'd0, w[19:15]});
    e64 = model(64, w, o, a, en, i64, w64);
    e32 = model(32, w, o, a, en, i32, w32);
    @(negedge clk);
    chk("R2", "valid64", {63'd0, v64}, {63'd0, vld});
    chk("R2", "valid32", {63'd0, v32}, {63'd0, vld});
    if (vld) begin
      chk(req, "result64", res64, e64);
      chk(req, "result32", {32'd0, res32}, e32);
      chk("R10", "illegal64", {63'd0, ill64}, {63'd0, i64});
      chk("R11", "illegal32", {63'd0, ill32}, {63'd0, i32});
      chk("R9", "we64", {63'd0, we64}, {63'd0, w64});
      chk("R9", "we32", {63'd0, we32}, {63'd0, w32});
      chk("R8", "rd64", {59'd0, rd64}, {59'd0, w[11:7]});
      chk("R8", "rd32", {59'd0, rd32}, {59'd0, w[11:7]});
    end else begin
      chk("R2", "flags idle", {62'd0, we64 | we32, ill64 | ill32}, 64'd0);
    end
    in_valid = 1'b0;
  endtask

  function automatic logic [31:0] mk(input logic [5:0] sh, input logic [4:0] s, input logic [4:0] d);
    return {6'b0, sh, s, 3'b001, d, 7'b0010011};
  endfunction

  initial begin
    #2_000_000;
    if (!done) begin
      fails++; vectors++;
      $display("FAIL watchdog: got timeout expected completion");
      $display("== %0d vectors applied, %0d miscompares ==", vectors, fails);
      $finish;
    end
  end

  initial begin
    logic [31:0] seed;
    seed = 32'd1234;
    void'($urandom(seed));
    repeat (3) @(negedge clk);
    chk("R1", "valid after reset", {62'd0, v64, v32}, 64'd0);
    chk("R1", "flags after reset", {60'd0, we64, we32, ill64, ill32}, 64'd0);
    rst = 1'b0;

    apply(mk(6'd0, 5'd1, 5'd3), 2'b00, 64'hFFFF_FFFF_FFFF_FFFF, 1'b1, 1'b1, "R4");
    apply(mk(6'd31, 5'd2, 5'd4), 2'b00, 64'hFFFF_FFFF_FFFF_FFFF, 1'b1, 1'b1, "R4");
    apply(mk(6'd63, 5'd2, 5'd4), 2'b11, 64'd0, 1'b1, 1'b1, "R7");
    apply(mk(6'd32, 5'd2, 5'd5), 2'b10, 64'h0000_0001_0000_0001, 1'b1, 1'b1, "R3");
    apply(mk(6'd40, 5'd6, 5'd7), 2'b01, 64'h0000_0100_0000_0000, 1'b1, 1'b1, "R5");
    apply(mk(6'd9, 5'd6, 5'd7), 2'b01, 64'h0000_0000_0000_0000, 1'b1, 1'b1, "R5");
    apply(mk(6'd9, 5'd6, 5'd7), 2'b01, 64'h0000_0000_0000_0200, 1'b1, 1'b1, "R5");
    apply(mk(6'd17, 5'd8, 5'd9), 2'b10, 64'h0000_0000_0002_0000, 1'b1, 1'b1, "R6");
    apply(mk(6'd5, 5'd8, 5'd0), 2'b11, 64'd0, 1'b1, 1'b1, "R9");
    apply(mk(6'd5, 5'd8, 5'd10), 2'b11, 64'd0, 1'b0, 1'b1, "R10");
    apply(mk(6'd33, 5'd8, 5'd10), 2'b11, 64'd0, 1'b1, 1'b1, "R11");
    apply(mk(6'd3, 5'd8, 5'd10), 2'b11, 64'd0, 1'b1, 1'b0, "R2");

    for (int k = 0; k < 400; k++) begin
      logic [31:0] w;
      logic en, vld;
      w   = $urandom;
      en  = ($urandom % 10) != 0;
      vld = ($urandom % 8) != 0;
      apply(w, 2'($urandom), {$urandom, $urandom}, en, vld, "R3");
    end

    done = 1'b1;
    $display("== %0d vectors applied, %0d miscompares ==", vectors, fails);
    $finish;
  end
endmodule